// File: doc/BRIEF.md
# I/O Window Configuration Gate

This block guards the register window of an ATA-style command block. In normal operation every host access passes straight through to the task-file registers. A host can open a hidden configuration bank only by making a fixed series of accesses on ordinary task-file offsets. The series is two 16-bit reads at the error-register offset, then a byte write of the key value at offset 2. Once the bank is open, the same offsets select configuration registers. These are read-cycle timing, write-cycle timing, control, strap and miscellaneous. A byte write of the closing key at offset 2 shuts the bank and restores pass-through.

The registers feed a timing engine. Writing the completion code to the control register switches the engine from the strap-selected default timings to the programmed ones. A flag output reports which of the two sets is in force. Reading the strap register reports the bus-clock strap pin in bit 0.

Top module: `iowin_trapdoor`

## Requirements
- R1: Reset (synchronous, active high) leaves the bank closed (`cfg_open`=0) with `prog_active`=0, and every configuration register reads back as zero once the bank is opened.
- R2: While closed, the bank opens on the clock edge of a byte write of 0x03 at offset 2, provided that write follows two 16-bit reads at offset 1 with no other access in between. Cycles with no access do not break the series.
- R3: Any other access while the series is pending sends the tracker back to its start and leaves the bank closed. This covers a byte read at offset 1, a third 16-bit read at offset 1, a write of another value to offset 2, or a write without the reads.
- R4: While closed, `tf_rd`, `tf_wr`, `tf_addr`, `tf_word` and `tf_wdata` mirror the host bus in the same cycle, and `bus_rdata` equals `tf_rdata`. Writes made while closed leave the configuration registers unchanged.
- R5: While open, the task-file strobes stay low. A byte write at offset 0, 1, 3, 5 or 6 stores the low data byte in that register. A read at that offset returns the value zero-extended to 16 bits in the same cycle.
- R6: While open, offsets 2, 4 and 7 read as zero and store nothing. A write of any value other than 0x83 at offset 2 leaves the bank open.
- R7: While open, a byte write of 0x83 at offset 2 closes the bank on that edge. All register contents are kept and can be read back after reopening.
- R8: A read of the strap register (offset 5) returns the strap pin in bit 0 and stored bits 7:1 above it.
- R9: A byte write of 0x85 to the control register (offset 3) sets `prog_active`, and any other value written there clears it. The control value is visible on `ctrl_cfg`.
- R10: One edge after any change, `rd_timing`/`wr_timing` equal the programmed registers 0 and 1 when `prog_active` is 1. Otherwise they show the defaults selected by the strap pin (pin 0: 0x77/0x7A, pin 1: 0x66/0x69).
- R11: `misc_cfg` shows the last byte written to offset 6. A second write replaces the first, so the device number can be followed by the address-setup value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Host offset within the window |
| bus_rd | input | 1 | Host read strobe, one cycle per access |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Host read data, same cycle as `bus_rd` |
| tf_rd | output | 1 | Read strobe to the task-file registers |
| tf_wr | output | 1 | Write strobe to the task-file registers |
| tf_addr | output | 3 | Offset to the task-file registers |
| tf_word | output | 1 | Size to the task-file registers |
| tf_wdata | output | 16 | Write data to the task-file registers |
| tf_rdata | input | 16 | Read data from the task-file registers |
| strap_clk | input | 1 | Bus-clock speed strap pin |
| cfg_open | output | 1 | Configuration bank is open |
| prog_active | output | 1 | Programmed timings are in force |
| rd_timing | output | 8 | Effective read-cycle timing |
| wr_timing | output | 8 | Effective write-cycle timing |
| ctrl_cfg | output | 8 | Control register contents |
| misc_cfg | output | 8 | Miscellaneous register contents |

## Verification
Read data and the task-file strobes are combinational, so the bench samples them 2 ns after driving an access on the falling edge, before the next rising edge. The bank state, register contents, `prog_active`, `ctrl_cfg` and `misc_cfg` change on the rising edge that takes the write. They are checked on the next falling edge. `rd_timing` and `wr_timing` need one more edge, so their checks wait one extra idle cycle after the control write or strap change.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ONE, SEQ_TWO} seq_e;

  localparam int OFS_ERR   = 1;
  localparam int OFS_GATE  = 2;
  localparam int IDX_RD    = 0;
  localparam int IDX_WR    = 1;
  localparam int IDX_CTRL  = 3;
  localparam int IDX_STRAP = 5;
  localparam int IDX_MISC  = 6;

  localparam logic [7:0] KEY_OPEN  = 8'h03;
  localparam logic [7:0] KEY_CLOSE = 8'h83;
  localparam logic [7:0] KEY_DONE  = 8'h85;
endpackage

// File: rtl/iowin_seq.sv
module iowin_seq
  import iowin_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              word_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              open_o
);
  seq_e state_q;
  logic key_rd, open_wr, close_wr, any_acc;

  assign any_acc  = rd_i | wr_i;
  assign key_rd   = rd_i && word_i && (addr_i == ADDR_W'(OFS_ERR));
  assign open_wr  = wr_i && !word_i && (addr_i == ADDR_W'(OFS_GATE)) && (wdata_i[7:0] == KEY_OPEN);
  assign close_wr = wr_i && !word_i && (addr_i == ADDR_W'(OFS_GATE)) && (wdata_i[7:0] == KEY_CLOSE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      open_o  <= 1'b0;
    end else if (open_o) begin
      state_q <= SEQ_IDLE;
      if (close_wr) open_o <= 1'b0;
    end else if (any_acc) begin
      unique case (state_q)
        SEQ_IDLE: state_q <= key_rd ? SEQ_ONE : SEQ_IDLE;
        SEQ_ONE:  state_q <= key_rd ? SEQ_TWO : SEQ_IDLE;
        default: begin
          state_q <= SEQ_IDLE;
          if (open_wr) open_o <= 1'b1;
        end
      endcase
    end
  end

  // R2: the bank opens only on the key write after two word reads
  assert_open_key_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(open_o) |-> $past(wr_i && !word_i && addr_i == ADDR_W'(OFS_GATE) && wdata_i[7:0] == 8'h03));

  // R3: a pending series never survives an access that is not a word read at offset 1
  assert_seq_reset_R3: assert property (@(posedge clk) disable iff (rst)
    (!open_o && any_acc && !(rd_i && word_i && addr_i == ADDR_W'(OFS_ERR))) |=> (state_q == SEQ_IDLE));

  // R7: the bank closes only on the closing key
  assert_close_key_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(open_o) |-> $past(wr_i && !word_i && addr_i == ADDR_W'(OFS_GATE) && wdata_i[7:0] == 8'h83));
endmodule

// File: rtl/iowin_cfgregs.sv
module iowin_cfgregs
  import iowin_pkg::*;
#(
  parameter int              ADDR_W   = 3,
  parameter int              DATA_W   = 16,
  parameter int              REG_W    = 8,
  parameter logic [(1<<ADDR_W)-1:0] REG_MASK = 8'b0110_1011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              open_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              word_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              strap_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [REG_W-1:0]  rd_tmg_o,
  output logic [REG_W-1:0]  wr_tmg_o,
  output logic [REG_W-1:0]  ctrl_o,
  output logic [REG_W-1:0]  misc_o,
  output logic              prog_o
);
  localparam int NREG = 1 << ADDR_W;

  logic [REG_W-1:0] cfg_q [NREG];
  logic             wr_en;
  logic [REG_W-1:0] rsel;

  assign wr_en = open_i && wr_i && !word_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) cfg_q[i] <= '0;
      prog_o <= 1'b0;
    end else if (wr_en) begin
      for (int i = 0; i < NREG; i++)
        if (REG_MASK[i] && addr_i == ADDR_W'(i)) cfg_q[i] <= wdata_i[REG_W-1:0];
      if (addr_i == ADDR_W'(IDX_CTRL)) prog_o <= (wdata_i[7:0] == KEY_DONE);
    end
  end

  always_comb begin
    rsel = cfg_q[addr_i];
    if (addr_i == ADDR_W'(IDX_STRAP)) rsel[0] = strap_i;
  end

  assign rdata_o  = DATA_W'(rsel);
  assign rd_tmg_o = cfg_q[IDX_RD];
  assign wr_tmg_o = cfg_q[IDX_WR];
  assign ctrl_o   = cfg_q[IDX_CTRL];
  assign misc_o   = cfg_q[IDX_MISC];

  // R4: a closed bank keeps every stored value
  assert_hold_closed_R4: assert property (@(posedge clk) disable iff (rst)
    !open_i |=> ($stable(rd_tmg_o) && $stable(wr_tmg_o) && $stable(ctrl_o) && $stable(misc_o)));

  // R9: the programmed flag rises only on the completion code at the control offset
  assert_prog_set_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(prog_o) |-> $past(open_i && wr_i && !word_i && addr_i == ADDR_W'(IDX_CTRL) && wdata_i[7:0] == 8'h85));

  // R8: strap reads always carry the pin in bit 0
  assert_strap_bit_R8: assert property (@(posedge clk) disable iff (rst)
    (addr_i == ADDR_W'(IDX_STRAP)) |-> (rdata_o[0] == strap_i));
endmodule

// File: rtl/iowin_trapdoor.sv
module iowin_trapdoor
  import iowin_pkg::*;
#(
  parameter int         ADDR_W     = 3,
  parameter int         DATA_W     = 16,
  parameter int         REG_W      = 8,
  parameter logic [7:0] DFLT_RD_S0 = 8'h77,
  parameter logic [7:0] DFLT_RD_S1 = 8'h66,
  parameter logic [7:0] DFLT_WR_S0 = 8'h7A,
  parameter logic [7:0] DFLT_WR_S1 = 8'h69
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              bus_word,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tf_rd,
  output logic              tf_wr,
  output logic [ADDR_W-1:0] tf_addr,
  output logic              tf_word,
  output logic [DATA_W-1:0] tf_wdata,
  input  logic [DATA_W-1:0] tf_rdata,
  input  logic              strap_clk,
  output logic              cfg_open,
  output logic              prog_active,
  output logic [REG_W-1:0]  rd_timing,
  output logic [REG_W-1:0]  wr_timing,
  output logic [REG_W-1:0]  ctrl_cfg,
  output logic [REG_W-1:0]  misc_cfg
);
  logic [DATA_W-1:0] cfg_rdata;
  logic [REG_W-1:0]  prg_rd, prg_wr;

  iowin_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .addr_i(bus_addr), .rd_i(bus_rd), .wr_i(bus_wr),
    .word_i(bus_word), .wdata_i(bus_wdata), .open_o(cfg_open)
  );

  iowin_cfgregs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst(rst), .open_i(cfg_open), .addr_i(bus_addr), .wr_i(bus_wr),
    .word_i(bus_word), .wdata_i(bus_wdata), .strap_i(strap_clk), .rdata_o(cfg_rdata),
    .rd_tmg_o(prg_rd), .wr_tmg_o(prg_wr), .ctrl_o(ctrl_cfg), .misc_o(misc_cfg),
    .prog_o(prog_active)
  );

  assign tf_rd     = bus_rd & ~cfg_open;
  assign tf_wr     = bus_wr & ~cfg_open;
  assign tf_addr   = bus_addr;
  assign tf_word   = bus_word;
  assign tf_wdata  = bus_wdata;
  assign bus_rdata = cfg_open ? cfg_rdata : tf_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_timing <= '0;
      wr_timing <= '0;
    end else begin
      rd_timing <= prog_active ? prg_rd : (strap_clk ? DFLT_RD_S1 : DFLT_RD_S0);
      wr_timing <= prog_active ? prg_wr : (strap_clk ? DFLT_WR_S1 : DFLT_WR_S0);
    end
  end

  // R5: no task-file strobe leaks while the bank is open
  assert_no_tf_open_R5: assert property (@(posedge clk) disable iff (rst)
    cfg_open |-> (!tf_rd && !tf_wr));

  // R6: empty offsets read as zero in the open bank
  assert_empty_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg_open && (bus_addr == 3'd2 || bus_addr == 3'd4 || bus_addr == 3'd7)) |-> (bus_rdata == '0));

  // R10: programmed timing follows the stored register one edge later
  assert_prog_timing_R10: assert property (@(posedge clk) disable iff (rst)
    $past(prog_active) |-> (rd_timing == $past(prg_rd) && wr_timing == $past(prg_wr)));
endmodule

// File: tb/sim_iowin_trapdoor.sv
module sim_iowin_trapdoor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_word = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata, tf_wdata, tf_rdata;
  logic        tf_rd, tf_wr, tf_word;
  logic [2:0]  tf_addr;
  logic        strap_clk = 1'b0;
  logic        cfg_open, prog_active;
  logic [7:0]  rd_timing, wr_timing, ctrl_cfg, misc_cfg;

  int checks = 0;
  int fails  = 0;
  logic [15:0] last_rd;
  logic        last_tfrd, last_tfwr;

  always #10 clk = ~clk;

  assign tf_rdata = {8'hA5, 5'd0, tf_addr};

  iowin_trapdoor u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tf_rd(tf_rd), .tf_wr(tf_wr), .tf_addr(tf_addr), .tf_word(tf_word),
    .tf_wdata(tf_wdata), .tf_rdata(tf_rdata), .strap_clk(strap_clk),
    .cfg_open(cfg_open), .prog_active(prog_active), .rd_timing(rd_timing),
    .wr_timing(wr_timing), .ctrl_cfg(ctrl_cfg), .misc_cfg(misc_cfg)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one access per cycle, driven on the falling edge, sampled 2 ns later
  task automatic acc(input logic [2:0] a, input logic rd, input logic wr,
                     input logic wd, input logic [15:0] d);
    bus_addr = a; bus_rd = rd; bus_wr = wr; bus_word = wd; bus_wdata = d;
    #2;
    last_rd = bus_rdata; last_tfrd = tf_rd; last_tfwr = tf_wr;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlock();
    acc(3'd1, 1, 0, 1, 0);
    acc(3'd1, 1, 0, 1, 0);
    acc(3'd2, 0, 1, 0, 16'h0003);
  endtask

  task automatic t_reset();
    idle(2);
    check("R1 open after reset", {15'd0, cfg_open}, 16'd0);
    check("R1 prog after reset", {15'd0, prog_active}, 16'd0);
    check("R10 default rd timing strap0", {8'd0, rd_timing}, 16'h0077);
    check("R10 default wr timing strap0", {8'd0, wr_timing}, 16'h007A);
  endtask

  task automatic t_passthru();
    acc(3'd3, 1, 0, 0, 0);
    check("R4 locked read data", last_rd, 16'hA503);
    check("R4 locked tf_rd", {15'd0, last_tfrd}, 16'd1);
    bus_addr = 3'd4; bus_wr = 1'b1; bus_word = 1'b1; bus_wdata = 16'hBEEF;
    #2;
    check("R4 locked tf_wr", {15'd0, tf_wr}, 16'd1);
    check("R4 locked tf_wdata", tf_wdata, 16'hBEEF);
    check("R4 locked tf_addr/word", {12'd0, tf_word, tf_addr}, 16'h000C);
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic t_unlock();
    acc(3'd1, 1, 0, 1, 0);
    acc(3'd1, 1, 0, 1, 0);
    idle(2);
    check("R2 not open before key", {15'd0, cfg_open}, 16'd0);
    acc(3'd2, 0, 1, 0, 16'h0003);
    check("R4 key write reaches task file", {15'd0, last_tfwr}, 16'd1);
    check("R2 open after key", {15'd0, cfg_open}, 16'd1);
    for (int i = 0; i < 8; i++) begin
      acc(3'(i), 1, 0, 0, 0);
      check($sformatf("R1 reg %0d zero", i), last_rd, (i == 5) ? 16'h0000 : 16'h0000);
    end
    check("R5 no tf_rd while open", {15'd0, last_tfrd}, 16'd0);
  endtask

  task automatic t_cfgwrite();
    acc(3'd0, 0, 1, 0, 16'h113C);
    acc(3'd1, 0, 1, 0, 16'h004D);
    check("R5 no tf_wr while open", {15'd0, last_tfwr}, 16'd0);
    acc(3'd0, 1, 0, 1, 0);
    check("R5 reg0 readback word", last_rd, 16'h003C);
    acc(3'd1, 1, 0, 0, 0);
    check("R5 reg1 readback byte", last_rd, 16'h004D);
    acc(3'd4, 0, 1, 0, 16'h00FF);
    acc(3'd7, 0, 1, 0, 16'h00FF);
    acc(3'd2, 0, 1, 0, 16'h0055);
    acc(3'd4, 1, 0, 0, 0);
    check("R6 offset 4 reads zero", last_rd, 16'h0000);
    acc(3'd7, 1, 0, 0, 0);
    check("R6 offset 7 reads zero", last_rd, 16'h0000);
    acc(3'd2, 1, 0, 0, 0);
    check("R6 offset 2 reads zero", last_rd, 16'h0000);
    check("R6 still open after other gate value", {15'd0, cfg_open}, 16'd1);
  endtask

  task automatic t_strap();
    acc(3'd5, 0, 1, 0, 16'h00FF);
    strap_clk = 1'b0;
    acc(3'd5, 1, 0, 1, 0);
    check("R8 strap read pin 0", last_rd, 16'h00FE);
    strap_clk = 1'b1;
    acc(3'd5, 1, 0, 1, 0);
    check("R8 strap read pin 1", last_rd, 16'h00FF);
    idle(1);
    check("R10 default rd timing strap1", {8'd0, rd_timing}, 16'h0066);
    check("R10 default wr timing strap1", {8'd0, wr_timing}, 16'h0069);
  endtask

  task automatic t_misc();
    acc(3'd6, 0, 1, 0, 16'h0001);
    check("R11 misc device number", {8'd0, misc_cfg}, 16'h0001);
    acc(3'd6, 0, 1, 0, 16'h0020);
    check("R11 misc replaced", {8'd0, misc_cfg}, 16'h0020);
  endtask

  task automatic t_prog();
    acc(3'd3, 0, 1, 0, 16'h0085);
    check("R9 prog set", {15'd0, prog_active}, 16'd1);
    check("R9 ctrl value", {8'd0, ctrl_cfg}, 16'h0085);
    idle(1);
    check("R10 programmed rd timing", {8'd0, rd_timing}, 16'h003C);
    check("R10 programmed wr timing", {8'd0, wr_timing}, 16'h004D);
    strap_clk = 1'b0;
    idle(2);
    check("R10 strap ignored while programmed", {8'd0, rd_timing}, 16'h003C);
    strap_clk = 1'b1;
    acc(3'd3, 0, 1, 0, 16'h0080);
    check("R9 prog cleared", {15'd0, prog_active}, 16'd0);
    idle(1);
    check("R10 back to default", {8'd0, rd_timing}, 16'h0066);
    acc(3'd3, 0, 1, 0, 16'h0085);
  endtask

  task automatic t_relock();
    acc(3'd2, 0, 1, 0, 16'h0083);
    check("R7 closed after key", {15'd0, cfg_open}, 16'd0);
    acc(3'd0, 1, 0, 0, 0);
    check("R4 task file after relock", last_rd, 16'hA500);
    acc(3'd0, 0, 1, 0, 16'h0099);
    check("R4 prog kept while closed", {15'd0, prog_active}, 16'd1);
    unlock();
    acc(3'd0, 1, 0, 0, 0);
    check("R7 reg0 retained", last_rd, 16'h003C);
    acc(3'd6, 1, 0, 0, 0);
    check("R7 misc retained", last_rd, 16'h0020);
    acc(3'd2, 0, 1, 0, 16'h0083);
  endtask

  task automatic t_broken();
    acc(3'd1, 1, 0, 1, 0); acc(3'd1, 1, 0, 0, 0); acc(3'd1, 1, 0, 1, 0);
    acc(3'd2, 0, 1, 0, 16'h0003);
    check("R3 byte read breaks series", {15'd0, cfg_open}, 16'd0);
    acc(3'd1, 1, 0, 1, 0); acc(3'd1, 1, 0, 1, 0);
    acc(3'd2, 0, 1, 0, 16'h0005);
    acc(3'd2, 0, 1, 0, 16'h0003);
    check("R3 wrong value breaks series", {15'd0, cfg_open}, 16'd0);
    acc(3'd1, 1, 0, 1, 0); acc(3'd1, 1, 0, 1, 0); acc(3'd1, 1, 0, 1, 0);
    acc(3'd2, 0, 1, 0, 16'h0003);
    check("R3 third read breaks series", {15'd0, cfg_open}, 16'd0);
    acc(3'd1, 1, 0, 1, 0); acc(3'd3, 1, 0, 0, 0); acc(3'd1, 1, 0, 1, 0);
    acc(3'd2, 0, 1, 0, 16'h0003);
    check("R3 other access breaks series", {15'd0, cfg_open}, 16'd0);
    acc(3'd0, 1, 0, 0, 0);
    check("R3 still task file", last_rd, 16'hA500);
    acc(3'd1, 1, 0, 1, 0); idle(3); acc(3'd1, 1, 0, 1, 0); idle(2);
    acc(3'd2, 0, 1, 0, 16'h0003);
    check("R2 idle gaps allowed", {15'd0, cfg_open}, 16'd1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_passthru();
    t_unlock();
    t_cfgwrite();
    t_strap();
    t_misc();
    t_prog();
    t_relock();
    t_broken();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule